// File: doc/BRIEF.md
# Posted-Write Register Bridge

This block connects a fast bus clock domain to a slow functional clock domain, such as a low-rate timer clock. The bus side issues single-cycle reads and writes. Every write to one of the five synchronized registers is copied into a holding register. It then crosses to the slow domain through a toggle handshake with two-flop synchronizers in each direction. The slow-domain copies of these registers stand in for the timer logic, which is not part of this block.

Each synchronized register has its own pending flag, and the flags can be read as one status word. In posted mode, which is the reset default, a write completes on the bus at once. While a register's flag is set, a write to that register is dropped and a read of it returns zero; both raise a one-cycle error. In non-posted mode the bridge holds the bus waiting until the write has landed. Registers without a pending flag are served directly in the bus domain.

Top module: `pwb_bridge`

## Requirements
- R1: After reset every pending flag is clear, posted mode is on (reading offset 0x40 gives 0x4), `bus_ready` is high and the slow-domain register copies are zero.
- R2: The synchronized registers and their pending-status bits are: control 0x24 (bit 0), counter 0x28 (bit 1), load 0x2C (bit 2), trigger 0x30 (bit 3) and match 0x38 (bit 4). An accepted write sets the register's bit in the status word at 0x34 from the cycle after the write.
- R3: A pending bit clears only after the slow-domain copy holds the written value. The copy updates about three functional-clock cycles after the write.
- R4: In posted mode, a write to a register whose pending bit is set is dropped, and `bus_err` is high in the cycle after it.
- R5: In posted mode, a read of a register whose pending bit is set returns zero, and `bus_err` is high in the cycle after it.
- R6: A read of a synchronized register whose pending bit is clear returns the last accepted write, and `bus_err` stays low.
- R7: In non-posted mode, `bus_ready` is low from the cycle after a synchronized write until that write lands. Requests made while `bus_ready` is low are ignored.
- R8: The identification register (0x00, read-only constant) and the interrupt-enable register (0x1C, read/write) are served at once. They never pend and never raise `bus_err`.
- R9: Pending bits are independent: writes to different registers can be in flight together, and each one lands with its own value.
- R10: Bit 2 of the interface control register at 0x40 selects posted mode (1) or non-posted mode (0). The new mode takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus (fast) clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| fn_clk | input | 1 | Functional (slow) clock |
| fn_rst | input | 1 | Synchronous active-high reset, functional domain |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after an accepted read |
| bus_ready | output | 1 | Low while a non-posted write is landing |
| bus_err | output | 1 | One-cycle pulse for a dropped write or an invalid read |
| fn_regs | output | 5*DATA_W | Slow-domain register copies, control in the lowest slice |

## Verification
The hardest cases to reach are the collision windows: a second write, or a read, that targets a register whose handshake has not yet come back. The bench reaches them by issuing the colliding access one or two bus cycles after the first write. With the slow clock at about fifteen bus periods, the flag is then certainly still set. Random register subsets written back to back keep several handshakes in flight together. A pulse issued in the middle of a non-posted stall checks that stalled requests have no effect.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int ADDR_W = 8;
    localparam int N_SYNC = 5;
    localparam int IDX_W  = $clog2(N_SYNC);

    localparam logic [ADDR_W-1:0] OFS_ID   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_IFC  = 8'h40;
    localparam int               IFC_POSTED_BIT = 2;

    // index equals the bit position in the pending word
    localparam logic [ADDR_W-1:0] SYNC_OFS [N_SYNC] =
        '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h38};

    typedef enum logic [2:0] {
        K_NONE, K_SYNC, K_PEND, K_IFC, K_ID, K_IEN
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t r;
        r.kind = K_NONE;
        r.idx  = '0;
        case (a)
            OFS_ID:   r.kind = K_ID;
            OFS_IEN:  r.kind = K_IEN;
            OFS_PEND: r.kind = K_PEND;
            OFS_IFC:  r.kind = K_IFC;
            default: begin
                for (int i = 0; i < N_SYNC; i++) begin
                    if (a == SYNC_OFS[i]) begin
                        r.kind = K_SYNC;
                        r.idx  = IDX_W'(i);
                    end
                end
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pwb_sync2.sv
module pwb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/pwb_chan.sv
module pwb_chan #(
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              fn_clk,
    input  logic              fn_rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic              pend,
    output logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] fn_q
);
    logic              req_tog_q;
    logic [DATA_W-1:0] hold_q;
    logic              ack_s;
    logic              req_s;
    logic              seen_q;
    logic [DATA_W-1:0] fn_val_q;

    // bus side: capture data, flip request
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_tog_q <= 1'b0;
            hold_q    <= '0;
        end else if (load) begin
            req_tog_q <= ~req_tog_q;
            hold_q    <= wdata;
        end
    end

    pwb_sync2 #(.W(1)) i_req_sync (
        .clk (fn_clk), .rst (fn_rst), .d (req_tog_q), .q (req_s)
    );

    // slow side: new toggle level copies the stable holding register
    always_ff @(posedge fn_clk) begin
        if (fn_rst) begin
            seen_q   <= 1'b0;
            fn_val_q <= '0;
        end else if (req_s != seen_q) begin
            seen_q   <= req_s;
            fn_val_q <= hold_q;
        end
    end

    pwb_sync2 #(.W(1)) i_ack_sync (
        .clk (bus_clk), .rst (bus_rst), .d (seen_q), .q (ack_s)
    );

    assign pend = req_tog_q ^ ack_s;
    assign hold = hold_q;
    assign fn_q = fn_val_q;
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
    parameter int                 DATA_W   = 32,
    parameter logic [DATA_W-1:0]  ID_VALUE = 32'h5042_0001
) (
    input  logic                              bus_clk,
    input  logic                              bus_rst,
    input  logic                              fn_clk,
    input  logic                              fn_rst,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [pwb_pkg::ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              bus_ready,
    output logic                              bus_err,
    output logic [pwb_pkg::N_SYNC*DATA_W-1:0] fn_regs
);
    import pwb_pkg::*;

    dec_t              dec;
    logic [N_SYNC-1:0] pend;
    logic [N_SYNC-1:0] chan_load;
    logic [DATA_W-1:0] hold [N_SYNC];
    logic              posted_q;
    logic [DATA_W-1:0] ien_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              acc_wr, acc_rd, sel_pend;
    logic [DATA_W-1:0] rd_val;

    assign dec       = decode(bus_addr);
    assign bus_ready = posted_q | ~(|pend);
    assign acc_wr    = bus_wr & bus_ready;
    assign acc_rd    = bus_rd & ~bus_wr & bus_ready;
    assign sel_pend  = (dec.kind == K_SYNC) && pend[dec.idx];

    for (genvar g = 0; g < N_SYNC; g++) begin : g_chan
        assign chan_load[g] = acc_wr && (dec.kind == K_SYNC) &&
                              (dec.idx == IDX_W'(g)) && !pend[g];
        pwb_chan #(.DATA_W(DATA_W)) i_chan (
            .bus_clk (bus_clk),
            .bus_rst (bus_rst),
            .fn_clk  (fn_clk),
            .fn_rst  (fn_rst),
            .load    (chan_load[g]),
            .wdata   (bus_wdata),
            .pend    (pend[g]),
            .hold    (hold[g]),
            .fn_q    (fn_regs[g*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        rd_val = '0;
        case (dec.kind)
            K_ID:   rd_val = ID_VALUE;
            K_IEN:  rd_val = ien_q;
            K_PEND: rd_val = DATA_W'(pend);
            K_IFC:  rd_val[IFC_POSTED_BIT] = posted_q;
            K_SYNC: rd_val = sel_pend ? '0 : hold[dec.idx];
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            posted_q <= 1'b1;
            ien_q    <= '0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= (acc_wr | acc_rd) & sel_pend & posted_q;
            if (acc_rd)
                rdata_q <= rd_val;
            if (acc_wr && dec.kind == K_IFC)
                posted_q <= bus_wdata[IFC_POSTED_BIT];
            if (acc_wr && dec.kind == K_IEN)
                ien_q <= bus_wdata;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
endmodule

// File: rtl/pwb_bridge_chk.sv
module pwb_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic                       bus_clk,
    input logic                       bus_rst,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [pwb_pkg::ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       bus_ready,
    input logic                       bus_err,
    input logic                       posted_q,
    input logic [pwb_pkg::N_SYNC-1:0] pend
);
    import pwb_pkg::*;

    // R1
    reset_state_chk: assert property (@(posedge bus_clk)
        bus_rst |=> (pend == '0 && posted_q && bus_ready && !bus_err));

    // R8
    direct_no_err_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        ((bus_wr || bus_rd) && bus_ready && bus_addr == OFS_IEN) |=> !bus_err);

    for (genvar g = 0; g < N_SYNC; g++) begin : g_prop
        // R2
        pend_set_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
            (bus_wr && bus_ready && bus_addr == SYNC_OFS[g] && !pend[g]) |=> pend[g]);
        // R4
        drop_err_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
            (bus_wr && posted_q && bus_addr == SYNC_OFS[g] && pend[g]) |=> bus_err);
        // R5
        bad_read_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
            (bus_rd && !bus_wr && posted_q && bus_addr == SYNC_OFS[g] && pend[g])
            |=> (bus_err && bus_rdata == '0));
        // R7
        stall_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
            (bus_wr && bus_ready && !posted_q && bus_addr == SYNC_OFS[g]) |=> !bus_ready);
    end
endmodule

bind pwb_bridge pwb_bridge_chk #(.DATA_W(DATA_W)) i_chk (
    .bus_clk   (bus_clk),
    .bus_rst   (bus_rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .posted_q  (posted_q),
    .pend      (pend)
);

// File: tb/test_pwb_bridge.sv
module test_pwb_bridge;
    localparam int DW = 32;
    localparam int NR = 5;
    localparam logic [7:0] A_ID = 8'h00, A_IEN = 8'h1C, A_PND = 8'h34, A_IFC = 8'h40;
    localparam logic [7:0] A_REG [NR] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h38};
    localparam logic [DW-1:0] IDV = 32'h5042_0001;

    logic bus_clk = 0, fn_clk = 0, bus_rst = 1, fn_rst = 1;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata;
    logic bus_ready, bus_err;
    logic [NR*DW-1:0] fn_regs;

    int n_tests = 0, n_fail = 0, cyc = 0;
    logic [DW-1:0] model [NR];

    always #10  bus_clk = ~bus_clk;
    always #155 fn_clk  = ~fn_clk;

    pwb_bridge #(.DATA_W(DW), .ID_VALUE(IDV)) i_pwb_bridge (
        .bus_clk, .bus_rst, .fn_clk, .fn_rst, .bus_wr, .bus_rd, .bus_addr,
        .bus_wdata, .bus_rdata, .bus_ready, .bus_err, .fn_regs
    );

    function automatic logic [DW-1:0] slot(input int i);
        return fn_regs[i*DW +: DW];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d, output logic e);
        @(negedge bus_clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 0;
        e = bus_err;
    endtask

    task automatic rd(input logic [7:0] a, output logic [DW-1:0] d, output logic e);
        @(negedge bus_clk);
        bus_rd = 1; bus_addr = a;
        @(negedge bus_clk);
        bus_rd = 0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic wait_idle(input string req);
        logic [DW-1:0] p; logic e;
        int n = 0;
        do begin
            rd(A_PND, p, e);
            n++;
        end while (p != 0 && n < 500);
        check(req, p, 0);
    endtask

    initial begin
        int unsigned seed_dummy;
        logic e; logic [DW-1:0] d; logic [DW-1:0] v1, v2;
        seed_dummy = $urandom(32'd4711);
        repeat (40) @(negedge bus_clk);
        bus_rst = 0; fn_rst = 0;
        repeat (2) @(negedge bus_clk);

        // R1 reset state
        check("R1 ready", {31'b0, bus_ready}, 1);
        for (int i = 0; i < NR; i++) check("R1 fn copy", slot(i), 0);
        rd(A_IFC, d, e); check("R1 mode", d, 32'h4);
        rd(A_PND, d, e); check("R1 pending", d, 0);

        // R8 direct registers
        rd(A_ID, d, e); check("R8 id", d, IDV); check("R8 id err", {31'b0, e}, 0);
        wr(A_IEN, 32'hA5A5_0F0F, e); check("R8 ien wr err", {31'b0, e}, 0);
        rd(A_IEN, d, e); check("R8 ien readback", d, 32'hA5A5_0F0F);
        rd(A_PND, d, e); check("R8 never pends", d, 0);

        // R2, R5, R4, R3, R6 on the control register
        v1 = 32'h1234_5678; v2 = 32'hDEAD_BEEF;
        wr(A_REG[0], v1, e); check("R2 posted no err", {31'b0, e}, 0);
        check("R2 ready kept", {31'b0, bus_ready}, 1);
        rd(A_PND, d, e); check("R2 pend bit0", d, 32'h1);
        rd(A_REG[0], d, e); check("R5 data", d, 0); check("R5 err", {31'b0, e}, 1);
        wr(A_REG[0], v2, e); check("R4 err", {31'b0, e}, 1);
        @(negedge bus_clk); check("R4 err one cycle", {31'b0, bus_err}, 0);
        wait_idle("R3 clears");
        check("R3 landed / R4 dropped", slot(0), v1);
        rd(A_REG[0], d, e); check("R6 readback", d, v1); check("R6 no err", {31'b0, e}, 0);
        model[0] = v1;
        for (int i = 1; i < NR; i++) model[i] = 0;

        // R9 random subsets in flight together
        for (int it = 0; it < 20; it++) begin
            int unsigned m;
            m = $urandom % 32;
            if (m == 0) m = 1 << (it % NR);
            for (int i = 0; i < NR; i++) begin
                if (m[i]) begin
                    model[i] = $urandom;
                    wr(A_REG[i], model[i], e);
                end
            end
            rd(A_PND, d, e); check("R9 pending mask", d, m);
            wait_idle("R9 idle");
            for (int i = 0; i < NR; i++) begin
                check("R9 fn copy", slot(i), model[i]);
                rd(A_REG[i], d, e); check("R6 random readback", d, model[i]);
            end
        end

        // R10 non-posted, R7 stall
        wr(A_IFC, 32'h0, e);
        rd(A_IFC, d, e); check("R10 mode off", d, 0);
        begin
            int stall = 0;
            logic [DW-1:0] match_before;
            match_before = model[4];
            v1 = 32'hCAFE_0042;
            @(negedge bus_clk);
            bus_wr = 1; bus_addr = A_REG[2]; bus_wdata = v1;
            @(negedge bus_clk);
            bus_wr = 0;
            check("R7 ready low", {31'b0, bus_ready}, 0);
            // a request during the stall is ignored
            bus_wr = 1; bus_addr = A_REG[4]; bus_wdata = 32'h0BAD_0BAD;
            @(negedge bus_clk);
            bus_wr = 0;
            while (!bus_ready && stall < 1000) begin
                @(negedge bus_clk);
                stall++;
            end
            check("R7 released", {31'b0, bus_ready}, 1);
            check("R7 landed at release", slot(2), v1);
            check("R7 stalled write ignored", slot(4), match_before);
            rd(A_PND, d, e); check("R7 nothing pending", d, 0);
            rd(A_REG[4], d, e); check("R7 match unchanged", d, match_before);
        end
        wr(A_IFC, 32'h4, e);
        rd(A_IFC, d, e); check("R10 mode on", d, 32'h4);
        wr(A_REG[3], 32'h77, e);
        check("R10 posted ready", {31'b0, bus_ready}, 1);
        wait_idle("R10 idle");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge bus_clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule